// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 24-bit virtual address into a 32-bit physical address by fetching one 4-byte entry from a flat, one-level page table in memory. A virtual page is 8 KB: the upper 11 bits of the virtual address select one of 2048 pages, and the lower 13 bits are the byte offset, which passes through to the physical address unchanged. The table's start address and its length in entries come in as inputs, together with an enable for translation. When translation is disabled, the address passes straight through and memory is not touched.

The walker takes one request at a time and reads the entry through a request/acknowledge memory port. It checks the entry's valid and writable flags and reports a fault code if either check fails. On a successful access it marks the entry as referenced, and on a write also as dirty. It writes the entry back to the same location only when one of those flags actually changed. The owner of the table, such as a fault handler, reads the fault code and decides what to do next.

Top module: `pte_walker`

## Requirements
- R1: On success, `rsp_paddr` is the entry's bits 31:13 (frame number) followed by virtual address bits 12:0, and `rsp_fault` is 0.
- R2: The entry is read from address `tbl_base + 4 * page`, where page is virtual address bits 23:13. A read is a cycle with `mem_req`=1 and `mem_we`=0.
- R3: If the page number is greater than or equal to `tbl_len`, the response is fault code 1, one cycle after the request, with no memory access.
- R4: If `paging_en`=0, the response is the virtual address zero-extended to 32 bits with fault 0, one cycle after the request, with no memory access.
- R5: An entry whose valid flag (bit 9) is 0 gives fault code 2, and the entry is not written.
- R6: A write request to a valid entry whose writable flag (bit 10) is 0 gives fault code 3, and the entry is not written.
- R7: A successful access sets the referenced flag (bit 11). A successful write also sets the dirty flag (bit 12). The entry is written back to the address it was read from only if its value changed, and all other bits are kept.
- R8: `busy` is high from the cycle after a request is accepted until the response. Requests seen while `busy` is high are ignored. `mem_req` stays high with a stable address and direction until `mem_ack`.
- R9: Every response with a nonzero fault code has `rsp_paddr` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request; taken when not busy |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_vaddr | input | 24 | Virtual address |
| tbl_base | input | 32 | Byte address of page table entry 0 |
| tbl_len | input | 12 | Number of entries in the table |
| paging_en | input | 1 | 1 = translate, 0 = pass the address through |
| busy | output | 1 | A table walk is in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 ok, 1 out of range, 2 invalid, 3 write protected |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = entry write-back, 0 = entry read |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_ack | input | 1 | Memory acknowledge; read data valid in the same cycle |
| mem_rdata | input | 32 | Entry read data |

## Verification
A wrong captured offset or frame shows up in `rsp_paddr` in the response cycle of the same translation. A wrong flag update stays hidden in memory until the next walk of that page. For that reason the bench compares its memory model with its own shadow table after every walk, and sweeps each page twice, so that a missed or extra write-back is seen at the latest on the second pass. A state machine stuck in a wait state shows up as a response that never arrives or a request that is never dropped. Each transaction is bounded, so this is caught within a few dozen cycles.

// File: rtl/pte_walker_pkg.sv
package pte_walker_pkg;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_RANGE   = 2'd1,
    FLT_INVALID = 2'd2,
    FLT_PROT    = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } walk_st_e;

  // flag positions inside a table entry
  localparam int unsigned VALID_BIT = 9;
  localparam int unsigned WR_BIT    = 10;
  localparam int unsigned REF_BIT   = 11;
  localparam int unsigned DIRTY_BIT = 12;

endpackage

// File: rtl/pte_walker_addr.sv
module pte_walker_addr #(
  parameter int unsigned VA_W  = 24,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 13
) (
  input  logic [VA_W-1:0]      vaddr_i,
  input  logic [PA_W-1:0]      base_i,
  input  logic [VA_W-OFF_W:0]  len_i,
  output logic                 in_range_o,
  output logic [PA_W-1:0]      pte_addr_o
);
  localparam int unsigned PN_W = VA_W - OFF_W;

  logic [PN_W-1:0] page;

  assign page       = vaddr_i[VA_W-1:OFF_W];
  assign in_range_o = ({1'b0, page} < len_i);
  assign pte_addr_o = base_i + (PA_W'(page) << 2);
endmodule

// File: rtl/pte_walker_eval.sv
module pte_walker_eval
  import pte_walker_pkg::*;
#(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 13
) (
  input  logic [PA_W-1:0]       entry_i,
  input  logic                  is_write_i,
  output fault_e                fault_o,
  output logic [PA_W-1:0]       entry_o,
  output logic                  need_wb_o,
  output logic [PA_W-OFF_W-1:0] frame_o
);
  always_comb begin
    entry_o = entry_i;
    fault_o = FLT_NONE;
    if (!entry_i[VALID_BIT]) begin
      fault_o = FLT_INVALID;
    end else if (is_write_i && !entry_i[WR_BIT]) begin
      fault_o = FLT_PROT;
    end else begin
      entry_o[REF_BIT] = 1'b1;
      if (is_write_i) entry_o[DIRTY_BIT] = 1'b1;
    end
  end

  assign need_wb_o = (fault_o == FLT_NONE) && (entry_o != entry_i);
  assign frame_o   = entry_i[PA_W-1:OFF_W];
endmodule

// File: rtl/pte_walker.sv
module pte_walker
  import pte_walker_pkg::*;
#(
  parameter int unsigned VA_W  = 24,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [VA_W-1:0]     req_vaddr,
  input  logic [PA_W-1:0]     tbl_base,
  input  logic [VA_W-OFF_W:0] tbl_len,
  input  logic                paging_en,
  output logic                busy,
  output logic                rsp_valid,
  output logic [PA_W-1:0]     rsp_paddr,
  output logic [1:0]          rsp_fault,
  output logic                mem_req,
  output logic                mem_we,
  output logic [PA_W-1:0]     mem_addr,
  output logic [PA_W-1:0]     mem_wdata,
  input  logic                mem_ack,
  input  logic [PA_W-1:0]     mem_rdata
);
  localparam int unsigned FN_W = PA_W - OFF_W;

  walk_st_e         state_q, state_d;
  logic             write_q;
  logic [OFF_W-1:0] off_q;
  logic [PA_W-1:0]  addr_q;
  logic [PA_W-1:0]  wdata_q, wdata_d;
  logic             rsp_valid_q, rsp_valid_d;
  logic [PA_W-1:0]  rsp_paddr_q, rsp_paddr_d;
  fault_e           rsp_fault_q, rsp_fault_d;

  logic             accept;
  logic             in_range;
  logic [PA_W-1:0]  pte_addr;
  fault_e           ev_fault;
  logic [PA_W-1:0]  ev_entry;
  logic             ev_need_wb;
  logic [FN_W-1:0]  ev_frame;

  pte_walker_addr #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_addr (
    .vaddr_i    (req_vaddr),
    .base_i     (tbl_base),
    .len_i      (tbl_len),
    .in_range_o (in_range),
    .pte_addr_o (pte_addr)
  );

  pte_walker_eval #(.PA_W(PA_W), .OFF_W(OFF_W)) u_eval (
    .entry_i    (mem_rdata),
    .is_write_i (write_q),
    .fault_o    (ev_fault),
    .entry_o    (ev_entry),
    .need_wb_o  (ev_need_wb),
    .frame_o    (ev_frame)
  );

  assign accept = req_valid && (state_q == ST_IDLE);

  // next-state logic
  always_comb begin
    state_d     = state_q;
    wdata_d     = wdata_q;
    rsp_valid_d = 1'b0;
    rsp_paddr_d = rsp_paddr_q;
    rsp_fault_d = rsp_fault_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (!paging_en) begin
            rsp_valid_d = 1'b1;
            rsp_paddr_d = PA_W'(req_vaddr);
            rsp_fault_d = FLT_NONE;
          end else if (!in_range) begin
            rsp_valid_d = 1'b1;
            rsp_paddr_d = '0;
            rsp_fault_d = FLT_RANGE;
          end else begin
            state_d = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (mem_ack) begin
          if (ev_fault != FLT_NONE) begin
            rsp_valid_d = 1'b1;
            rsp_paddr_d = '0;
            rsp_fault_d = ev_fault;
            state_d     = ST_IDLE;
          end else if (ev_need_wb) begin
            wdata_d = ev_entry;
            state_d = ST_WRITE;
          end else begin
            rsp_valid_d = 1'b1;
            rsp_paddr_d = {ev_frame, off_q};
            rsp_fault_d = FLT_NONE;
            state_d     = ST_IDLE;
          end
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          rsp_valid_d = 1'b1;
          rsp_paddr_d = {wdata_q[PA_W-1:OFF_W], off_q};
          rsp_fault_d = FLT_NONE;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      write_q     <= 1'b0;
      off_q       <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_paddr_q <= '0;
      rsp_fault_q <= FLT_NONE;
    end else begin
      state_q     <= state_d;
      wdata_q     <= wdata_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_paddr_q <= rsp_paddr_d;
      rsp_fault_q <= rsp_fault_d;
      if (accept) begin
        write_q <= req_write;
        off_q   <= req_vaddr[OFF_W-1:0];
        addr_q  <= pte_addr;
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign mem_req   = (state_q != ST_IDLE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_paddr = rsp_paddr_q;
  assign rsp_fault = rsp_fault_q;

  // memory request held steady until acknowledged
  p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // any memory traffic happens only inside a busy window
  p_busy_covers_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // faulting responses carry a zero physical address
  p_fault_paddr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault != 2'd0) |-> rsp_paddr == '0);

  // write-back follows an acknowledged read of the same address
  p_wb_same_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(mem_req) && $past(mem_ack) && (mem_addr == $past(mem_addr)));

  // written entry always carries referenced, and dirty for writes
  p_wb_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[REF_BIT] && mem_wdata[VALID_BIT] &&
                          (mem_wdata[DIRTY_BIT] || !write_q));
endmodule

// File: tb/pte_walker_bench.sv
module pte_walker_bench;
  localparam int NPG  = 64;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [23:0] req_vaddr;
  logic [31:0] tbl_base;
  logic [11:0] tbl_len;
  logic        paging_en;
  logic        busy, rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ack;

  int checks, errors, cycles;
  int n_reads, n_writes, mem_lat, wcnt;
  logic [31:0] last_rd_addr;
  logic [31:0] mem     [NPG];
  logic [31:0] exp_tbl [NPG];

  pte_walker u_pte_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_vaddr(req_vaddr), .tbl_base(tbl_base), .tbl_len(tbl_len),
    .paging_en(paging_en), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // memory model
  logic [31:0] moff;
  logic        m_in;
  assign moff = mem_addr - BASE;
  assign m_in = (moff < 32'(NPG * 4)) && (moff[1:0] == 2'b00);
  assign mem_rdata = m_in ? mem[moff[7:2]] : 32'h0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end else begin
      if (mem_req && !mem_ack) begin
        if (wcnt >= mem_lat) begin
          mem_ack <= 1'b1;
          wcnt    <= 0;
        end else wcnt <= wcnt + 1;
      end else mem_ack <= 1'b0;
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          n_writes <= n_writes + 1;
          if (m_in) mem[moff[7:2]] <= mem_wdata;
        end else begin
          n_reads      <= n_reads + 1;
          last_rd_addr <= mem_addr;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] make_entry(input int p);
    logic [18:0] fr;
    logic [3:0]  fl;
    fr = 19'(p * 37 + 5);
    fl = 4'(p);
    return {fr, fl[3], fl[2], fl[1], fl[0], 9'(p * 3)};
  endfunction

  // one translation; returns response and latency
  task automatic xlate(input bit wr, input logic [23:0] va, input bit poke,
                       output logic [1:0] f, output logic [31:0] pa,
                       output int lat, output int dr, output int dw);
    int r0, w0;
    while (busy) @(negedge clk);
    r0 = n_reads; w0 = n_writes;
    req_valid = 1'b1; req_write = wr; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 60) begin
      if (poke && busy) begin
        req_valid = 1'b1; req_write = ~wr; req_vaddr = va ^ 24'h7FE000;
      end else req_valid = 1'b0;
      @(negedge clk);
      lat = lat + 1;
    end
    req_valid = 1'b0;
    chk(rsp_valid, "R8", "response arrived", 32'(rsp_valid), 32'd1);
    f = rsp_fault; pa = rsp_paddr;
    dr = n_reads - r0; dw = n_writes - w0;
    mem_lat = (mem_lat + 1) % 3;
  endtask

  // full translation with expected values from the shadow table
  task automatic run_page(input int p, input bit wr, input bit poke);
    logic [23:0] va;
    logic [12:0] off;
    logic [1:0]  f, ef;
    logic [31:0] pa, epa, e, ne;
    int lat, dr, dw, ewr;
    off = 13'(p * 101 + (wr ? 7 : 0));
    va  = {11'(p), off};
    xlate(wr, va, poke, f, pa, lat, dr, dw);
    if (32'(p) >= 32'(tbl_len)) begin
      chk(f == 2'd1, "R3", "range fault", 32'(f), 32'd1);
      chk(dr == 0 && dw == 0, "R3", "no memory access", 32'(dr + dw), 32'd0);
      chk(lat == 1, "R3", "latency", 32'(lat), 32'd1);
      chk(pa == 32'h0, "R9", "paddr on fault", pa, 32'h0);
    end else begin
      e = exp_tbl[p]; ne = e; ewr = 0; epa = 32'h0; ef = 2'd0;
      if (!e[9]) ef = 2'd2;
      else if (wr && !e[10]) ef = 2'd3;
      else begin
        ne[11] = 1'b1;
        if (wr) ne[12] = 1'b1;
        ewr = (ne != e) ? 1 : 0;
        epa = {e[31:13], off};
        exp_tbl[p] = ne;
      end
      chk(dr == 1, "R2", "one entry read", 32'(dr), 32'd1);
      chk(last_rd_addr == BASE + 32'(p * 4), "R2", "entry address",
          last_rd_addr, BASE + 32'(p * 4));
      if (ef == 2'd2) chk(f == ef, "R5", "invalid fault", 32'(f), 32'(ef));
      else if (ef == 2'd3) chk(f == ef, "R6", "protection fault", 32'(f), 32'(ef));
      else chk(f == 2'd0, "R1", "no fault", 32'(f), 32'd0);
      chk(pa == epa, ef != 0 ? "R9" : "R1", "physical address", pa, epa);
      chk(dw == ewr, ef != 0 ? "R5" : "R7", "write-back count", 32'(dw), 32'(ewr));
      chk(mem[p] == exp_tbl[p], "R7", "table entry after walk", mem[p], exp_tbl[p]);
    end
    if (poke) begin
      int r1;
      r1 = n_reads;
      repeat (3) begin
        @(negedge clk);
        chk(!rsp_valid && !busy, "R8", "ignored request left no trace",
            32'({rsp_valid, busy}), 32'd0);
      end
      chk(n_reads == r1, "R8", "no extra read", 32'(n_reads), 32'(r1));
    end
  endtask

  initial begin
    logic [1:0]  f;
    logic [31:0] pa;
    int lat, dr, dw;
    checks = 0; errors = 0; cycles = 0;
    n_reads = 0; n_writes = 0; mem_lat = 0; last_rd_addr = 32'h0;
    req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0;
    tbl_base = BASE; tbl_len = 12'd48; paging_en = 1'b1;
    for (int p = 0; p < NPG; p++) begin
      mem[p] = make_entry(p);
      exp_tbl[p] = make_entry(p);
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !rsp_valid && !mem_req, "R8", "reset state",
        32'({busy, rsp_valid, mem_req}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // two sweeps over every page, read then write: second pass hits set flags
    for (int pass = 0; pass < 2; pass++)
      for (int p = 0; p < NPG; p++)
        for (int w = 0; w < 2; w++)
          run_page(p, w[0], (p % 5) == 0);

    // pass-through with translation off
    paging_en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      logic [23:0] va;
      va = (k == 7) ? 24'hFFFFFF : 24'(k * 24'h2F5A3 + 1);
      xlate(k[0], va, 1'b0, f, pa, lat, dr, dw);
      chk(pa == {8'h0, va}, "R4", "pass-through address", pa, {8'h0, va});
      chk(f == 2'd0 && dr == 0 && dw == 0, "R4", "no fault, no access",
          32'({f, 8'(dr + dw)}), 32'd0);
      chk(lat == 1, "R4", "latency", 32'(lat), 32'd1);
    end
    paging_en = 1'b1;

    // empty table: page 0 already out of range
    tbl_len = 12'd0;
    run_page(0, 1'b0, 1'b0);
    // full-size table: top page is in range, read from far address
    tbl_len = 12'd2048;
    xlate(1'b0, 24'hFFE123, 1'b0, f, pa, lat, dr, dw);
    chk(dr == 1 && last_rd_addr == BASE + 32'(2047 * 4), "R2", "top page address",
        last_rd_addr, BASE + 32'(2047 * 4));
    chk(f == 2'd2 && dw == 0, "R5", "zero entry is invalid", 32'(f), 32'd2);
    // boundary page at length-1 and at length
    tbl_len = 12'd10;
    run_page(9, 1'b1, 1'b0);
    run_page(10, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule